// File: doc/BRIEF.md
# Alarm Interrupt and Status Register

This block sits between the alarm detectors of a line interface and a host register port. It watches three alarm levels: loss of signal, alarm indication and network loop. Any change on one of them, in either direction, sets a sticky change flag for that source. An active-low interrupt line is asserted while any change flag is set for a source that is not masked. The host acknowledges a source by writing 1 to its control bit. That write clears the source's flag and masks the source. Writing 0 to the bit unmasks the source again.

A status register gives a 3-bit summary code in bits 7:5. The code reports the pending LOS and network-loop change flags when there are any. Otherwise it reports the loopback and all-ones-transmit states that the datapath presents. Reads have no side effects.

The host port is a plain register port with an address, write data, a write strobe, a read strobe and read data. There is no data stream and no back-pressure: every strobe is accepted in the cycle it is high. The alarm and loop-state pins are plain level inputs.

Top module: `alarm_irq_regs`

## Requirements
- R1: After reset, `irq_n` is 1, all change flags are 0 and all mask bits are 0, so the control and status registers both read 0x00.
- R2: A change of either polarity on an alarm input sets that source's change flag. If the source is unmasked, `irq_n` goes low on the third rising clock edge after the input changes.
- R3: Reading any register never clears a change flag or releases `irq_n`.
- R4: A write to the control register (address 0) sets each mask bit that has a 1 in write data and clears the change flag of that source. Bit 0 is LOS, bit 1 is AIS and bit 2 is network loop. `irq_n` returns high on the second rising edge after the write when nothing unmasked is pending.
- R5: A masked source still latches its change flag, and the flag is visible in status, but it never pulls `irq_n` low.
- R6: A control write with 0 in a bit clears that mask bit. If the source's flag is already pending, `irq_n` goes low on the second rising edge after the write.
- R7: Status (address 1) bits 2:0 hold the change flags in control-bit order, and bits 4:3 read 0. Bits 7:5 read 011 when only the LOS flag is set, 101 when only the network-loop flag is set, and 111 when both are set.
- R8: With neither the LOS nor the network-loop flag set, status bits 7:5 encode the loop states. The code is 110 for all-ones and local loopback together, 100 for all-ones alone, 010 for local loopback, 001 for remote loopback and 000 for none, checked in that priority order. Any set LOS or network-loop flag takes priority over the loop-state codes.
- R9: `rd_data` updates on the rising edge where `rd_en` is high and holds otherwise. The control register reads back the mask bits in bits 2:0. Any address other than 0 and 1 reads 0x00.
- R10: If an alarm change reaches the flag logic in the same cycle as a write of 1 that clears that source, the flag ends up set. The mask bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | 1 | Loss-of-signal level |
| ais_i | input | 1 | Alarm-indication level |
| nloop_i | input | 1 | Network-loop level |
| rloop_act | input | 1 | Remote loopback active |
| lloop_act | input | 1 | Local loopback active |
| allones_act | input | 1 | All-ones transmit active |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
If a change flag is stuck or lost, the status read taken a few cycles after the stimulus shows a wrong code in bits 7:5 or a wrong bit in 2:0. If a mask bit is wrong, it shows on `irq_n` within two to three cycles: the line is either missing or cannot be released. The bench times the detection and release latencies exactly, so an added or dropped register stage shows up as a level mismatch on the cycle it samples. It also covers the same-cycle race between a clear write and a new change.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_LOS   = 0;
  localparam int SRC_AIS   = 1;
  localparam int SRC_NLOOP = 2;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'b000,
    ST_RLOOP     = 3'b001,
    ST_LLOOP     = 3'b010,
    ST_LOS_CHG   = 3'b011,
    ST_ONES      = 3'b100,
    ST_NLOOP_CHG = 3'b101,
    ST_ONES_LLP  = 3'b110,
    ST_BOTH_CHG  = 3'b111
  } stat_code_t;
endpackage

// File: rtl/alarm_edge.sv
module alarm_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_in,
  output logic [WIDTH-1:0] edge_pulse
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_src
    logic cur_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        cur_q  <= lvl_in[i];
        prev_q <= cur_q;
      end
    end
    assign edge_pulse[i] = cur_q ^ prev_q;
  end
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] edge_pulse,
  input  logic             ctl_wr,
  input  logic [WIDTH-1:0] ctl_bits,
  output logic [WIDTH-1:0] chg_flags,
  output logic [WIDTH-1:0] src_mask,
  output logic             irq_n
);
  logic [WIDTH-1:0] clr_vec;
  logic [WIDTH-1:0] flag_nxt;
  logic             any_live;

  always_comb begin
    clr_vec  = ctl_wr ? ctl_bits : '0;
    // a fresh change outranks a clear in the same cycle
    flag_nxt = (chg_flags & ~clr_vec) | edge_pulse;
    any_live = |(chg_flags & ~src_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_flags <= '0;
      src_mask  <= '0;
      irq_n     <= 1'b1;
    end else begin
      chg_flags <= flag_nxt;
      if (ctl_wr) src_mask <= ctl_bits;
      irq_n <= ~any_live;
    end
  end
endmodule

// File: rtl/status_encode.sv
module status_encode
  import alarm_irq_pkg::*;
(
  input  logic       los_chg,
  input  logic       nloop_chg,
  input  logic       rloop_act,
  input  logic       lloop_act,
  input  logic       allones_act,
  output stat_code_t code
);
  always_comb begin
    if (los_chg && nloop_chg)         code = ST_BOTH_CHG;
    else if (los_chg)                 code = ST_LOS_CHG;
    else if (nloop_chg)               code = ST_NLOOP_CHG;
    else if (allones_act && lloop_act) code = ST_ONES_LLP;
    else if (allones_act)             code = ST_ONES;
    else if (lloop_act)               code = ST_LLOOP;
    else if (rloop_act)               code = ST_RLOOP;
    else                              code = ST_IDLE;
  end
endmodule

// File: rtl/alarm_irq_regs.sv
module alarm_irq_regs
  import alarm_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los_i,
  input  logic              ais_i,
  input  logic              nloop_i,
  input  logic              rloop_act,
  input  logic              lloop_act,
  input  logic              allones_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int CODE_LSB = DATA_W - 3;

  logic [NUM_SRC-1:0] src_lvl;
  logic [NUM_SRC-1:0] edge_pulse;
  logic [NUM_SRC-1:0] chg_flags;
  logic [NUM_SRC-1:0] src_mask;
  logic               ctl_wr;
  stat_code_t         stat_code;
  logic [DATA_W-1:0]  rd_mux;

  always_comb begin
    src_lvl[SRC_LOS]   = los_i;
    src_lvl[SRC_AIS]   = ais_i;
    src_lvl[SRC_NLOOP] = nloop_i;
  end

  assign ctl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  alarm_edge #(.WIDTH(NUM_SRC)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_in     (src_lvl),
    .edge_pulse (edge_pulse)
  );

  alarm_flags #(.WIDTH(NUM_SRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_pulse (edge_pulse),
    .ctl_wr     (ctl_wr),
    .ctl_bits   (wr_data[NUM_SRC-1:0]),
    .chg_flags  (chg_flags),
    .src_mask   (src_mask),
    .irq_n      (irq_n)
  );

  status_encode u_enc (
    .los_chg     (chg_flags[SRC_LOS]),
    .nloop_chg   (chg_flags[SRC_NLOOP]),
    .rloop_act   (rloop_act),
    .lloop_act   (lloop_act),
    .allones_act (allones_act),
    .code        (stat_code)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rd_mux[NUM_SRC-1:0] = src_mask;
    end else if (addr == ADDR_W'(STAT_ADDR)) begin
      rd_mux[NUM_SRC-1:0]     = chg_flags;
      rd_mux[DATA_W-1:CODE_LSB] = stat_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/alarm_irq_regs_chk.sv
module alarm_irq_regs_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        edge_pulse,
  input logic [2:0]        chg_flags,
  input logic [2:0]        src_mask,
  input logic              irq_n,
  input logic [2:0]        stat_code
);
  assert_edge_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_pulse) |=> ((chg_flags & $past(edge_pulse)) == $past(edge_pulse)));

  assert_read_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(chg_flags) & ~chg_flags)) |-> $past(wr_en && addr == ADDR_W'(CTRL_ADDR)));

  assert_mask_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CTRL_ADDR)) |=> (src_mask == $past(wr_data[2:0])));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_flags & ~src_mask) == 3'b000) |=> irq_n);

  assert_both_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'b111) |-> (chg_flags[0] && chg_flags[2]));

  assert_clear_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CTRL_ADDR) && |(edge_pulse & wr_data[2:0]))
      |=> |chg_flags);
endmodule

bind alarm_irq_regs alarm_irq_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .edge_pulse (edge_pulse),
  .chg_flags  (chg_flags),
  .src_mask   (src_mask),
  .irq_n      (irq_n),
  .stat_code  (stat_code)
);

// File: tb/alarm_irq_regs_test.sv
`timescale 1ns/1ps
module alarm_irq_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       los_i = 0, ais_i = 0, nloop_i = 0;
  logic       rloop_act = 0, lloop_act = 0, allones_act = 0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  logic       rd_seen = 1'b0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  alarm_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .los_i(los_i), .ais_i(ais_i), .nloop_i(nloop_i),
    .rloop_act(rloop_act), .lloop_act(lloop_act), .allones_act(allones_act),
    .addr(addr), .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    addr = a; rd_en = 1'b1;
    q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n=%b expected=%b", t, irq_n, e);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(2);
    chk_irq(1'b1, "R1 reset irq");
    rd(4'd1, 8'h00, "R1 reset status");
    rd(4'd0, 8'h00, "R1 reset mask");

    los_i = 1'b1;
    waitn(2);
    chk_irq(1'b1, "R2 before third edge");
    waitn(1);
    chk_irq(1'b0, "R2 after third edge");
    rd(4'd1, 8'h61, "R7 los only");
    rd(4'd1, 8'h61, "R3 reread");
    waitn(2);
    chk_irq(1'b0, "R3 irq held after reads");

    wr(4'd0, 8'h01);
    waitn(1);
    chk_irq(1'b1, "R4 release");
    rd(4'd1, 8'h00, "R4 flag cleared");
    rd(4'd0, 8'h01, "R9 mask readback");

    los_i = 1'b0;
    waitn(4);
    chk_irq(1'b1, "R5 masked quiet");
    rd(4'd1, 8'h61, "R5 masked flag latched");

    wr(4'd0, 8'h00);
    waitn(1);
    chk_irq(1'b0, "R6 unmask pending");
    wr(4'd0, 8'h01);
    wr(4'd0, 8'h00);
    waitn(2);
    chk_irq(1'b1, "R6 cleared and unmasked");

    nloop_i = 1'b1;
    waitn(4);
    chk_irq(1'b0, "R2 nloop irq");
    rd(4'd1, 8'hA4, "R7 nloop only");
    los_i = 1'b1;
    waitn(4);
    rd(4'd1, 8'hE5, "R7 both");
    ais_i = 1'b1;
    waitn(4);
    rd(4'd1, 8'hE7, "R7 ais flag bit");
    wr(4'd0, 8'h07);
    waitn(1);
    chk_irq(1'b1, "R4 clear all");
    rd(4'd1, 8'h00, "R4 all flags cleared");
    wr(4'd0, 8'h00);
    waitn(2);

    rloop_act = 1'b1;
    rd(4'd1, 8'h20, "R8 remote loop");
    lloop_act = 1'b1;
    rd(4'd1, 8'h40, "R8 local over remote");
    allones_act = 1'b1;
    rd(4'd1, 8'hC0, "R8 ones and local");
    lloop_act = 1'b0;
    rd(4'd1, 8'h80, "R8 ones");

    los_i = 1'b0;
    waitn(4);
    rd(4'd1, 8'h61, "R8 flag over loop state");
    chk_irq(1'b0, "R2 falling edge irq");
    wr(4'd0, 8'h01);
    wr(4'd0, 8'h00);
    waitn(2);

    los_i = 1'b1;
    waitn(1);
    wr(4'd0, 8'h01);
    waitn(1);
    chk_irq(1'b1, "R10 masked after race");
    rd(4'd1, 8'h61, "R10 change wins");
    rd(4'd0, 8'h01, "R10 mask set");

    rd(4'd5, 8'h00, "R9 unused address");
    waitn(3);
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R9 hold: rd_data=%h expected=%h", rd_data, 8'h00);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule